// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a simple host request port and one rank of single-data-rate SDRAM. The memory has four internal banks, a 12-bit row address and a 9-bit column address. After reset the block holds the bus idle for a configurable settling time. It then precharges every bank, runs two refresh cycles and writes the mode register. Once that is done it serves one host read or write at a time. A refresh timer runs in the background and its refreshes take precedence over host traffic.

Every access follows the same closed-page pattern. The block opens the row, issues the column command with auto-precharge set on A10, and then waits until the row cycle and the write recovery have both expired. Only then does the next command go out. All spacings are counted in clocks. A parameter picks one of two speed profiles: latency 3 with the longer clock counts, or latency 2 with the shorter ones. Read data is sampled a fixed latency after the read command and is handed back with a one-clock strobe.

Top module: `sdr_cmd_seq`

## Requirements
- R1: While `rst` is high, the command bus carries no-operation (cs_n,ras_n,cas_n,we_n = 0,1,1,1), and `req_ready` and `rd_valid` are low.
- R2: After reset the first four non-NOP commands are, in order: precharge with A10=1 (all banks), auto refresh, auto refresh, mode register set. The precharge comes no earlier than POWERUP_CYC clocks after reset release. The first refresh is at least tRP after the precharge. The second refresh is at least tRRC after the first. The mode register set is at least tRRC after the second refresh. The next command is at least 2 clocks after the mode register set.
- R3: The mode register set drives BA=0 and an address word with burst length 1 in A[2:0]=000, sequential order in A3=0, the CAS latency in A[6:4] and zeros in every other bit. That word is 0x030 for profile 0 (latency 3) and 0x020 for profile 1 (latency 2).
- R4: Commands are encoded on (cs_n,ras_n,cas_n,we_n) as follows: mode set 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. The block issues no other code.
- R5: A host address is split as bank = addr[22:21], row = addr[20:9] and column = addr[8:0]. An access issues an activate with the row on A and the bank on BA. Exactly tRCD clocks later it issues the read or write, with the column on A[8:0], A10=1 and the same BA.
- R6: The write data is driven on `sd_dq_out` with `sd_dq_oe` high in the same clock as the write command. `sd_dq_oe` is low in every other clock.
- R7: For a read command issued in clock k, `sd_dq_in` is sampled at the end of clock k+CL. `rd_valid` is high for exactly clock k+CL+1, and `rd_data` then holds the value most recently written to that address.
- R8: An activate or refresh comes at least tRC after the previous activate, at least 5 clocks after a write command and at least tRRC after the previous refresh. Profile 0 uses CL 3, tRCD 3, tRC 9, tRP 3 and tRRC 9. Profile 1 uses CL 2, tRCD 2, tRC 7, tRP 2 and tRRC 7.
- R9: After initialisation, refresh commands repeat every REFRESH_INTERVAL clocks. Each gap is within tRC+2 clocks of that interval, even under continuous host traffic.
- R10: A refresh that falls due during an access is issued as the first command after that access's row cycle. It goes ahead of any host request that is waiting, and `req_ready` stays low while it is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-clock strobe for read data |
| rd_data | output | 16 | Returned read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed address |
| sd_dq_out | output | 16 | Data toward memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The assertions take for granted that the host holds `req_write`, `req_addr` and `req_wdata` steady while `req_valid` waits for `req_ready`. They also take for granted that the memory presents read data only in the clock the latency defines, and that reset lasts at least one clock. The stimulus follows these rules: a driver task changes the request fields only after an acceptance. A memory model in the bench drives `sd_dq_in` with a real value only in the expected clock and with a changing junk pattern in every other clock. Randomised requests go to a small set of rows and columns so that reads often hit earlier writes. Directed cases cover the address extremes and back-to-back traffic that keeps refreshes competing with host requests.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    F_CL, F_TRCD, F_TRAS, F_TRC, F_TRP, F_TRRC
  } prof_field_e;

  localparam int TMRD_CYC = 2;
  localparam int TDAL_CYC = 5;

  // profile 0: 7.5 ns clock, profile 1: 10 ns clock
  function automatic int prof(input int sel, input prof_field_e f);
    int v;
    v = 0;
    if (sel == 0) begin
      case (f)
        F_CL:    v = 3;
        F_TRCD:  v = 3;
        F_TRAS:  v = 6;
        F_TRC:   v = 9;
        F_TRP:   v = 3;
        default: v = 9;
      endcase
    end else begin
      case (f)
        F_CL:    v = 2;
        F_TRCD:  v = 2;
        F_TRAS:  v = 5;
        F_TRC:   v = 7;
        F_TRP:   v = 2;
        default: v = 7;
      endcase
    end
    return v;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int W    = 16,
  parameter int INIT = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= W'(INIT);
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R8
  load_when_expired_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> zero);

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)
        pend <= 1'b1;
      else if (ack)
        pend <= 1'b0;
    end
  end

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int CL     = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [CL:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe     <= {pipe[CL-1:0], launch};
      rd_valid <= pipe[CL];
      if (pipe[CL])
        rd_data <= dq_in;
    end
  end

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
  import sdr_seq_pkg::*;
#(
  parameter int SPEED_SEL        = 0,
  parameter int POWERUP_CYC      = 26600,
  parameter int REFRESH_INTERVAL = 1560,
  parameter int DATA_W           = 16,
  parameter int BANK_W           = 2,
  parameter int ROW_W            = 12,
  parameter int COL_W            = 9
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in
);
  localparam int CL     = prof(SPEED_SEL, F_CL);
  localparam int TRCD   = prof(SPEED_SEL, F_TRCD);
  localparam int TRC    = prof(SPEED_SEL, F_TRC);
  localparam int TRP    = prof(SPEED_SEL, F_TRP);
  localparam int TRRC   = prof(SPEED_SEL, F_TRRC);
  localparam int RD_GAP = max2(TRC - TRCD, CL + 1);
  localparam int WR_GAP = max2(TRC - TRCD, TDAL_CYC);
  localparam int TMR_W  = $clog2(POWERUP_CYC + 32);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CL << 4);

  typedef enum logic [2:0] {
    ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_COL
  } seq_state_e;

  seq_state_e  st, st_d;
  sdr_cmd_e    cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_d;
  logic [ROW_W-1:0]  addr_d;
  logic [DATA_W-1:0] dout_d;
  logic              oe_d;

  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             ref_pend, ref_ack;
  logic             accept, launch_rd;

  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;

  sdr_wait_timer #(.W(TMR_W), .INIT(POWERUP_CYC - 1)) i_wait (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sdr_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) i_refresh (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend)
  );

  sdr_rd_capture #(.CL(CL), .DATA_W(DATA_W)) i_capture (
    .clk(clk), .rst(rst), .launch(launch_rd), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign req_ready = (st == ST_IDLE) && tmr_zero && !ref_pend;

  always_comb begin
    st_d      = st;
    cmd_d     = CMD_NOP;
    ba_d      = sd_ba;
    addr_d    = sd_addr;
    dout_d    = sd_dq_out;
    oe_d      = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    ref_ack   = 1'b0;
    accept    = 1'b0;
    launch_rd = 1'b0;
    if (tmr_zero) begin
      case (st)
        ST_PWR: begin
          cmd_d      = CMD_PRE;
          addr_d     = '0;
          addr_d[10] = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = TMR_W'(TRP - 1);
          st_d       = ST_IREF1;
        end
        ST_IREF1: begin
          cmd_d    = CMD_REF;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(TRRC - 1);
          st_d     = ST_IREF2;
        end
        ST_IREF2: begin
          cmd_d    = CMD_REF;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(TRRC - 1);
          st_d     = ST_IMRS;
        end
        ST_IMRS: begin
          cmd_d    = CMD_MRS;
          ba_d     = '0;
          addr_d   = MODE_WORD;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(TMRD_CYC - 1);
          st_d     = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_d    = CMD_REF;
            ref_ack  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TRRC - 1);
          end else if (req_valid) begin
            cmd_d    = CMD_ACT;
            ba_d     = req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
            addr_d   = req_addr[ROW_W+COL_W-1 -: ROW_W];
            accept   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TRCD - 1);
            st_d     = ST_COL;
          end
        end
        ST_COL: begin
          cmd_d               = wr_q ? CMD_WR : CMD_RD;
          ba_d                = bank_q;
          addr_d              = '0;
          addr_d[COL_W-1:0]   = col_q;
          addr_d[10]          = 1'b1;
          oe_d                = wr_q;
          dout_d              = wdata_q;
          launch_rd           = !wr_q;
          tmr_load            = 1'b1;
          tmr_val             = wr_q ? TMR_W'(WR_GAP - 1) : TMR_W'(RD_GAP - 1);
          st_d                = ST_IDLE;
        end
        default: st_d = ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PWR;
      cmd_q     <= CMD_NOP;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      wr_q      <= 1'b0;
      bank_q    <= '0;
      col_q     <= '0;
      wdata_q   <= '0;
    end else begin
      st        <= st_d;
      cmd_q     <= cmd_d;
      sd_ba     <= ba_d;
      sd_addr   <= addr_d;
      sd_dq_out <= dout_d;
      sd_dq_oe  <= oe_d;
      if (accept) begin
        wr_q    <= req_write;
        bank_q  <= req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
        col_q   <= req_addr[COL_W-1:0];
        wdata_q <= req_wdata;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  // R5
  act_then_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));

  // R5
  col_autopre_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_addr[10]);

  // R6
  oe_only_write_chk: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe |-> (cmd_q == CMD_WR));

  // R10
  ref_first_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_pend && st == ST_IDLE && tmr_zero) |=> (cmd_q == CMD_REF));

endmodule

// File: tb/test_sdr_cmd_seq.sv
module test_sdr_cmd_seq;
  localparam int PU = 50, RI = 200;
  localparam int CL = 3, TRCD = 3, TRC = 9, TRP = 3, TRRC = 9;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0, sd_dq_in = '0;
  logic req_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;

  sdr_cmd_seq #(.SPEED_SEL(0), .POWERUP_CYC(PU), .REFRESH_INTERVAL(RI)) i_sdr_cmd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  always #4 clk = ~clk;

  int cyc = 0, nchk = 0, nerr = 0;
  bit done = 0;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(input logic [22:0] a);
    return a[15:0] ^ 16'hC3A5;
  endfunction

  logic [15:0] hmem [int];
  logic [15:0] mmem [int];
  int          acc_a [$];
  bit          acc_w [$];
  logic [15:0] acc_d [$];
  logic [15:0] exp_q [$];

  // memory model and protocol monitor
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  int last_act = -1000, last_wr = -1000, last_ref = -1000, last_pre = -1000, last_mrs = -1000;
  int init_n = 0, rd_cmd = -1000, rd_due = -1, prev_ref = -1, nref = 0;
  bit first_post = 1;
  int act_ba = 0, act_row = 0;
  logic [15:0] rd_drive = '0;

  always @(negedge clk) begin
    if (rst) begin
      check(cmd == C_NOP && !req_ready && !rd_valid, "R1 reset idle", cmd, C_NOP);
    end else begin
      if (cyc == rd_due) sd_dq_in <= rd_drive;
      else sd_dq_in <= 16'hBAD0 ^ cyc[15:0];
      if (rd_valid) begin
        check(cyc == rd_cmd + CL + 1, "R7 strobe clock", cyc, rd_cmd + CL + 1);
        if (exp_q.size() > 0) begin
          check(rd_data == exp_q[0], "R7 read data", rd_data, exp_q[0]);
          void'(exp_q.pop_front());
        end else check(0, "R7 spurious strobe", 1, 0);
      end
      if (sd_dq_oe || cmd == C_WR)
        check(sd_dq_oe && cmd == C_WR, "R6 oe with write only", sd_dq_oe, cmd == C_WR);
      if (cmd != C_NOP) begin
        if (init_n < 4) begin
          case (init_n)
            0: begin
              check(cmd == C_PRE && sd_addr[10], "R2 first is precharge all", cmd, C_PRE);
              check(cyc >= PU, "R2 powerup wait", cyc, PU);
              last_pre = cyc;
            end
            1: begin
              check(cmd == C_REF, "R2 second is refresh", cmd, C_REF);
              check(cyc - last_pre >= TRP, "R2 tRP", cyc - last_pre, TRP);
              last_ref = cyc;
            end
            2: begin
              check(cmd == C_REF, "R2 third is refresh", cmd, C_REF);
              check(cyc - last_ref >= TRRC, "R2 tRRC", cyc - last_ref, TRRC);
              last_ref = cyc;
            end
            default: begin
              check(cmd == C_MRS, "R2 fourth is mode set", cmd, C_MRS);
              check(cyc - last_ref >= TRRC, "R2 tRRC before mode", cyc - last_ref, TRRC);
              check(sd_addr == 12'h030 && sd_ba == 2'd0, "R3 mode word", sd_addr, 12'h030);
              last_mrs = cyc;
            end
          endcase
          init_n++;
        end else begin
          if (first_post) begin
            check(cyc - last_mrs >= 2, "R2 tMRD", cyc - last_mrs, 2);
            first_post = 0;
          end
          case (cmd)
            C_ACT, C_REF: begin
              check(cyc - last_act >= TRC, "R8 tRC", cyc - last_act, TRC);
              check(cyc - last_wr >= 5, "R8 write to activate", cyc - last_wr, 5);
              check(cyc - last_ref >= TRRC, "R8 tRRC", cyc - last_ref, TRRC);
              if (cmd == C_ACT) begin
                last_act = cyc; act_ba = sd_ba; act_row = sd_addr;
              end else begin
                if (prev_ref >= 0) begin
                  check(cyc - prev_ref <= RI + TRC + 2, "R9 R10 refresh gap max", cyc - prev_ref, RI + TRC + 2);
                  check(cyc - prev_ref >= RI - TRC - 2, "R9 refresh gap min", cyc - prev_ref, RI - TRC - 2);
                end
                prev_ref = cyc; last_ref = cyc; nref++;
              end
            end
            C_WR, C_RD: begin
              int a;
              a = {act_ba[1:0], act_row[11:0], sd_addr[8:0]};
              check(cyc - last_act == TRCD, "R5 tRCD", cyc - last_act, TRCD);
              check(sd_addr[10] && sd_ba == act_ba[1:0], "R5 auto-precharge and bank", sd_addr[10], 1);
              if (acc_a.size() > 0) begin
                check(a == acc_a[0] && (cmd == C_WR) == acc_w[0], "R5 address map", a, acc_a[0]);
                if (cmd == C_WR)
                  check(sd_dq_out == acc_d[0] && sd_dq_oe, "R6 write data", sd_dq_out, acc_d[0]);
                void'(acc_a.pop_front()); void'(acc_w.pop_front()); void'(acc_d.pop_front());
              end else check(0, "R5 unrequested access", a, 0);
              if (cmd == C_WR) begin
                mmem[a] = sd_dq_out; last_wr = cyc;
              end else begin
                rd_cmd = cyc; rd_due = cyc + CL;
                rd_drive = mmem.exists(a) ? mmem[a] : dflt(a[22:0]);
              end
            end
            default: check(0, "R4 unexpected command code", cmd, C_NOP);
          endcase
        end
      end
    end
  end

  task automatic do_req(input bit w, input logic [22:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (1) begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    acc_a.push_back(int'(a)); acc_w.push_back(w); acc_d.push_back(d);
    if (w) hmem[int'(a)] = d;
    else exp_q.push_back(hmem.exists(int'(a)) ? hmem[int'(a)] : dflt(a));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [22:0] mk(input int b, input int r, input int c);
    return {b[1:0], 12'(r * 1013 + 5), 9'(c * 73)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // directed: address extremes, write then read back
    do_req(1, 23'h7FFFFF, 16'hA55A);
    do_req(1, 23'h000000, 16'h1234);
    do_req(0, 23'h7FFFFF, 16'h0);
    do_req(0, 23'h000000, 16'h0);
    do_req(0, 23'h155555, 16'h0);   // never written: default pattern
    do_req(1, 23'h155555, 16'hFFFF);
    do_req(0, 23'h155555, 16'h0);
    // random mix with idle gaps and back-to-back bursts
    for (int n = 0; n < 400; n++) begin
      do_req($urandom_range(0, 1) == 1,
             mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7)),
             16'($urandom));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 20)) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
    check(acc_a.size() == 0, "R5 all accesses issued", acc_a.size(), 0);
    check(nref >= (cyc - PU) / RI - 2, "R9 refresh count", nref, (cyc - PU) / RI - 2);
    finish_run();
  end
endmodule